// File: doc/BRIEF.md
# One-time-programmable memory programming-mode controller

This block guards and serves the programming interface of an on-chip one-time-programmable code store. It samples a set of control pins on every clock and admits the part into programming mode only when those pins follow a strict order. First a fixed idle pattern must hold. Then the select line must fall. Only after that may the write strobe rise. Once the block is in the mode, two mode-select lines choose the access. The choices are a memory byte, the protection lock bits, or a read of a fixed version byte. The write and read strobes move data over a split 8-bit data port that has an output enable.

The memory is a behavioural byte array. Its bits start erased at 1, and programming can only clear bits. Addresses are 16 bits wide and arrive as two bytes on one 8-bit address port. The low byte is captured while the address-latch strobe is high. The port value present during the access supplies the high byte. The array keeps only the low `MEM_AW` address bits, so higher addresses alias onto it. The supply level arrives as a 2-bit digital flag. A nonzero protection level that is still set when the mode is left blocks every later entry.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), `pgm_active` is 0, `data_oe` is 0, the lock level is 0 and every memory byte reads 8'hFF.
- R2: `pgm_active` becomes 1 on the clock after the entry sequence completes. The sequence has three steps. (1) One sampled cycle with `sys_rst`=1, `store_en`=0, `wr_stb`=0, `ale`=0, `rd_stb`=1, `pick`=1, `mode_sel`=2'b01 and `supply_lvl`=2'b00. (2) A cycle with `pick`=0 while the other pins keep those levels. (3) A cycle with `wr_stb`=1.
- R3: The block does not enter the mode in two cases: when `wr_stb` rises before `pick` falls, and when any precondition is wrong at the cycle where `pick` falls.
- R4: If `mode_sel` leaves 2'b01 after `pick` has fallen but before `wr_stb` rises, entry is abandoned and `pgm_active` stays 0.
- R5: While in the mode, `sys_rst`=0, `store_en`=1 or `pick`=1 in any sampled cycle clears `pgm_active` on the next clock.
- R6: With `mode_sel`=2'b11 and the programming level present (`supply_lvl[1]`=1), a falling edge of `wr_stb` stores old AND `data_in` into the addressed byte. With `supply_lvl`=2'b01 the same pulse leaves the byte unchanged.
- R7: `data_oe` is 1 only in the mode, with `rd_stb`=0, a nonzero `supply_lvl` and `mode_sel` other than 2'b00. With `mode_sel`=2'b11 it presents the addressed byte on `data_out`.
- R8: The address is {high byte, low byte}. The low byte is the `addr_in` value captured in the last cycle with `ale`=1. The high byte is the live `addr_in`. Only the low `MEM_AW` bits (default 10) select the byte.
- R9: With `mode_sel`=2'b10, a program pulse raises the lock level to `data_in[1:0]` when that value is higher and never lowers it. A read returns {6'b0, level}.
- R10: With `mode_sel`=2'b01, a read returns a version byte chosen by the live `addr_in`. Address 8'h30 returns 8'h5A, address 8'h31 returns 8'hA7, and every other address returns 8'hFF. A program pulse in this mode changes nothing.
- R11: Leaving the mode with a nonzero lock level blocks every later entry until power-on reset. With level 0, the mode can be re-entered.
- R12: With `supply_lvl`=2'b00 in the mode, `data_oe` stays 0 and program pulses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst | input | 1 | Reset pin level, must be 1 in the mode |
| store_en | input | 1 | Program-store-enable pin level, must be 0 in the mode |
| pick | input | 1 | Select line whose falling edge starts entry |
| ale | input | 1 | Address-latch strobe, high captures low address byte |
| wr_stb | input | 1 | Write strobe, a falling edge is a program pulse |
| rd_stb | input | 1 | Read strobe, active low |
| mode_sel | input | 2 | Access mode select |
| supply_lvl | input | 2 | Supply flag: 00 low, 01 read level, 1x programming level |
| addr_in | input | 8 | Address port |
| data_in | input | 8 | Data port, inward |
| data_out | output | 8 | Data port, outward |
| data_oe | output | 1 | Data port output enable |
| pgm_active | output | 1 | Programming mode active |

## Verification
The bench targets several places where a near-miss design goes wrong. It checks the order of the entry steps: a design that accepted the write strobe before the select edge, or ignored a mode-select change while it waited, would enter the mode. It writes bytes several times at aliased addresses, so a design that overwrote instead of ANDing, or that decoded the wrong address bits, reads back the wrong value. It tries a lower lock level and a program pulse at read level, either of which a careless design would honour. It also programs a lock level, exits and tries again: a design that forgot the lock-out would show `pgm_active` rising.

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl #(
  parameter int MEM_AW = 10,
  parameter logic [7:0] SIG_ADDR0 = 8'h30,
  parameter logic [7:0] SIG_VAL0  = 8'h5A,
  parameter logic [7:0] SIG_ADDR1 = 8'h31,
  parameter logic [7:0] SIG_VAL1  = 8'hA7
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst,
  input  logic       store_en,
  input  logic       pick,
  input  logic       ale,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [1:0] mode_sel,
  input  logic [1:0] supply_lvl,
  input  logic [7:0] addr_in,
  input  logic [7:0] data_in,
  output logic [7:0] data_out,
  output logic       data_oe,
  output logic       pgm_active
);
  localparam int DEPTH = 1 << MEM_AW;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_WAIT, S_ACT} st_t;

  st_t        st;
  logic [7:0] mem [DEPTH];
  logic [7:0] lo_q;
  logic [1:0] lock;
  logic       blocked;
  logic       wr_q;

  wire hold_ok  = sys_rst & ~store_en;
  wire quiet_ok = hold_ok & ~wr_stb & ~ale & rd_stb & (mode_sel == 2'b01) & (supply_lvl == 2'b00);
  wire powered  = supply_lvl != 2'b00;
  wire [15:0] full_addr = {addr_in, lo_q};
  wire [MEM_AW-1:0] idx = full_addr[MEM_AW-1:0];
  wire in_mode  = st == S_ACT;
  wire leaving  = ~hold_ok | pick;
  wire wr_pulse = in_mode & ~leaving & supply_lvl[1] & wr_q & ~wr_stb;

  logic [7:0] sig_byte;
  always_comb begin
    if (addr_in == SIG_ADDR0)      sig_byte = SIG_VAL0;
    else if (addr_in == SIG_ADDR1) sig_byte = SIG_VAL1;
    else                           sig_byte = 8'hFF;
  end

  assign pgm_active = in_mode;
  assign data_oe    = in_mode & powered & ~rd_stb & (mode_sel != 2'b00);

  always_comb begin
    case (mode_sel)
      2'b11:   data_out = mem[idx];
      2'b10:   data_out = {6'b0, lock};
      2'b01:   data_out = sig_byte;
      default: data_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= S_IDLE;
      lo_q    <= 8'h00;
      lock    <= 2'b00;
      blocked <= 1'b0;
      wr_q    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      wr_q <= wr_stb;
      if (ale) lo_q <= addr_in;
      case (st)
        S_IDLE:  if (quiet_ok & pick & ~blocked) st <= S_ARMED;
        S_ARMED: begin
          if (quiet_ok & ~pick)   st <= S_WAIT;
          else if (!quiet_ok)     st <= S_IDLE;
        end
        S_WAIT: begin
          if (leaving | (mode_sel != 2'b01)) st <= S_IDLE;
          else if (wr_stb)                   st <= S_ACT;
        end
        S_ACT: begin
          if (leaving) begin
            st <= S_IDLE;
            if (lock != 2'b00) blocked <= 1'b1;
          end else if (wr_pulse) begin
            if (mode_sel == 2'b11) mem[idx] <= mem[idx] & data_in;
            else if (mode_sel == 2'b10 && data_in[1:0] > lock) lock <= data_in[1:0];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module otp_prog_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst,
  input logic       store_en,
  input logic       pick,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic [1:0] supply_lvl,
  input logic       pgm_active,
  input logic       data_oe,
  input logic [1:0] lock,
  input logic       blocked
);
  // R2
  entry_order_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pgm_active) |-> $past(wr_stb) && !$past(pick));
  // R5
  exit_on_pin_chk: assert property (@(posedge clk) disable iff (!por_n)
    pgm_active && (!sys_rst || store_en || pick) |=> !pgm_active);
  // R7
  drive_needs_read_chk: assert property (@(posedge clk) disable iff (!por_n)
    data_oe |-> pgm_active && !rd_stb);
  // R12
  no_drive_unpowered_chk: assert property (@(posedge clk) disable iff (!por_n)
    supply_lvl == 2'b00 |-> !data_oe);
  // R9
  lock_monotonic_chk: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> lock >= $past(lock));
  // R11
  blocked_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    blocked |=> blocked);
  // R11
  blocked_no_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    blocked && !pgm_active |=> !pgm_active);
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .store_en(store_en),
  .pick(pick), .wr_stb(wr_stb), .rd_stb(rd_stb), .supply_lvl(supply_lvl),
  .pgm_active(pgm_active), .data_oe(data_oe), .lock(lock), .blocked(blocked)
);

// File: tb/test_otp_prog_ctrl.sv
module test_otp_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 0, por_n = 0, sys_rst = 0, store_en = 1, pick = 0, ale = 0;
  logic wr_stb = 0, rd_stb = 1;
  logic [1:0] mode_sel = 2'b00, supply_lvl = 2'b00;
  logic [7:0] addr_in = 0, data_in = 0, data_out;
  logic data_oe, pgm_active;

  int tests = 0, fails = 0;
  logic [7:0] model [1 << AW];
  logic [1:0] m_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_prog_ctrl i_otp_prog_ctrl (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .store_en(store_en), .pick(pick),
    .ale(ale), .wr_stb(wr_stb), .rd_stb(rd_stb), .mode_sel(mode_sel),
    .supply_lvl(supply_lvl), .addr_in(addr_in), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .pgm_active(pgm_active)
  );

  function automatic int midx(input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] a = {hi, lo};
    return int'(a[AW-1:0]);
  endfunction

  function automatic logic [7:0] sig_exp(input logic [7:0] a);
    if (a == 8'h30) return 8'h5A;
    if (a == 8'h31) return 8'hA7;
    return 8'hFF;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic quiet();
    sys_rst = 1; store_en = 0; wr_stb = 0; ale = 0; rd_stb = 1;
    mode_sel = 2'b01; supply_lvl = 2'b00; pick = 1;
  endtask

  task automatic enter();
    quiet(); cyc();
    pick = 0; cyc();
    wr_stb = 1; cyc();
  endtask

  task automatic wr_byte(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] d);
    ale = 1; addr_in = lo; cyc();
    ale = 0; addr_in = hi; data_in = d; wr_stb = 0; cyc();
    wr_stb = 1; cyc();
  endtask

  task automatic rd_byte(input logic [7:0] lo, input logic [7:0] hi,
                         output logic [7:0] q, output logic oe);
    ale = 1; addr_in = lo; cyc();
    ale = 0; addr_in = hi; rd_stb = 0; #1;
    q = data_out; oe = data_oe;
    rd_stb = 1; cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] q, lo, hi, d;
    logic oe;
    void'($urandom(32'd2024));
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
    repeat (3) cyc();
    // R1
    chk("R1 mode", {7'b0, pgm_active}, 8'h00);
    chk("R1 oe", {7'b0, data_oe}, 8'h00);
    por_n = 1; cyc();

    // R3: write strobe rises before the select edge
    quiet(); cyc();
    wr_stb = 1; cyc();
    pick = 0; cyc(); cyc();
    chk("R3 order", {7'b0, pgm_active}, 8'h00);
    // R3: supply not low at the select edge
    quiet(); cyc();
    supply_lvl = 2'b01; pick = 0; cyc();
    wr_stb = 1; cyc(); cyc();
    chk("R3 precondition", {7'b0, pgm_active}, 8'h00);
    // R4
    quiet(); cyc();
    pick = 0; cyc();
    mode_sel = 2'b11; cyc();
    wr_stb = 1; cyc();
    chk("R4 abort", {7'b0, pgm_active}, 8'h00);

    // R2
    enter();
    chk("R2 entry", {7'b0, pgm_active}, 8'h01);

    // R12
    mode_sel = 2'b11; supply_lvl = 2'b00;
    rd_byte(8'h05, 8'h00, q, oe);
    chk("R12 no drive", {7'b0, oe}, 8'h00);
    wr_byte(8'h05, 8'h00, 8'h00);
    supply_lvl = 2'b01;
    rd_byte(8'h05, 8'h00, q, oe);
    chk("R12 no write", q, 8'hFF);
    // R1, R7
    chk("R7 oe", {7'b0, oe}, 8'h01);
    ale = 0; addr_in = 8'h00; #1;
    chk("R7 idle strobe", {7'b0, data_oe}, 8'h00);
    // R6: read level ignores program pulse
    wr_byte(8'h07, 8'h00, 8'h0F);
    rd_byte(8'h07, 8'h00, q, oe);
    chk("R6 read level", q, 8'hFF);

    // R6, R8: random programs with aliasing high bytes
    for (int n = 0; n < 300; n++) begin
      lo = 8'($urandom_range(0, 7));
      hi = 8'($urandom);
      d  = 8'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        supply_lvl = ($urandom_range(0, 1) == 1) ? 2'b10 : 2'b11;
        wr_byte(lo, hi, d);
        model[midx(lo, hi)] = model[midx(lo, hi)] & d;
      end else begin
        supply_lvl = 2'b01;
        rd_byte(lo, hi, q, oe);
        chk("R6 R8 byte", q, model[midx(lo, hi)]);
      end
    end
    // R8: low byte held while ale low
    supply_lvl = 2'b01;
    ale = 1; addr_in = 8'h03; cyc();
    ale = 0; addr_in = 8'h04; cyc(); cyc();
    rd_stb = 0; #1;
    chk("R8 latch", data_out, model[midx(8'h03, 8'h04)]);
    rd_stb = 1; cyc();

    // R10
    mode_sel = 2'b01;
    for (int a = 8'h2F; a <= 8'h32; a++) begin
      rd_byte(8'h00, 8'(a), q, oe);
      chk("R10 version", q, sig_exp(8'(a)));
    end
    supply_lvl = 2'b10;
    wr_byte(8'h00, 8'h30, 8'h00);
    supply_lvl = 2'b01;
    rd_byte(8'h00, 8'h30, q, oe);
    chk("R10 no write", q, 8'h5A);

    // R5 and R11 with level 0: exit via store_en then re-enter
    store_en = 1; cyc();
    chk("R5 store_en exit", {7'b0, pgm_active}, 8'h00);
    enter();
    chk("R11 reentry level 0", {7'b0, pgm_active}, 8'h01);
    sys_rst = 0; cyc();
    chk("R5 reset exit", {7'b0, pgm_active}, 8'h00);
    enter();
    chk("R2 entry again", {7'b0, pgm_active}, 8'h01);
    mode_sel = 2'b11; supply_lvl = 2'b01;
    rd_byte(8'h01, 8'h00, q, oe);
    chk("R1 R6 array kept", q, model[midx(8'h01, 8'h00)]);

    // R9
    mode_sel = 2'b10; supply_lvl = 2'b10;
    wr_byte(8'h00, 8'h00, 8'hFE);
    m_lock = 2'b10;
    supply_lvl = 2'b01;
    rd_byte(8'h00, 8'h00, q, oe);
    chk("R9 lock raise", q, {6'b0, m_lock});
    supply_lvl = 2'b11;
    wr_byte(8'h00, 8'h00, 8'h01);
    supply_lvl = 2'b01;
    rd_byte(8'h00, 8'h00, q, oe);
    chk("R9 lock no lower", q, {6'b0, m_lock});

    // R5 select exit, R11 lock-out
    pick = 1; cyc();
    chk("R5 select exit", {7'b0, pgm_active}, 8'h00);
    enter();
    chk("R11 lockout", {7'b0, pgm_active}, 8'h00);
    enter(); cyc();
    chk("R11 lockout again", {7'b0, pgm_active}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule